// File: doc/BRIEF.md
# Overcurrent Latch-Off Fault Controller

This block is the digital supervisor for a pair of current-limited load switches. The two channels are identical and do not interact. Each channel watches its own enable input and overcurrent flag, along with a shared supply-good flag that reports the input rail is above its undervoltage threshold. From these it produces one-hot gate-drive mode controls and an active-low fault output.

When a channel is enabled and the supply is good, it starts a soft turn-on. For a fixed blanking window after turn-on, fault reporting is held off, so inrush current does not raise a fault. An overcurrent indication moves the channel into current regulation and starts a grace timer. If the overcurrent goes away before the timer runs out, the channel returns to normal conduction. If the timer runs out, the channel latches off with a fast pulldown and drops its fault line once. The fault line stays low until the channel is disabled or the supply fails.

A disabled channel always engages its output clamp. The shutdown speed depends on the state the channel was in when it was disabled. A channel that was conducting normally ramps down slowly. A channel that was regulating or latched is pulled down fast. Both windows are clock-tick counts, 12 ms at the default clock, and a bench can override them.

Top module: `ocp_latch_ctrl`

## Requirements
- R1: The two channels are independent: the enable, overcurrent flag, timers, latch and outputs of one channel never change those of the other.
- R2: A channel leaves the off state only when its enable is high and `sup_ok` is high; it starts driving (`drive_on`=1) one clock after both are seen high.
- R3: `fault_n` of a channel stays high until the channel has spent BLANK_TICKS clocks in a powered state since its last turn-on, even if it has already latched off.
- R4: An overcurrent flag seen while conducting switches the channel to current regulation (`drive_reg`=1, `drive_on`=0) on the next clock.
- R5: If the overcurrent flag is held for GRACE_TICKS clocks of regulation, the channel latches off (`pull_fast`=1), and `fault_n` goes low once blanking has elapsed.
- R6: While latched and still enabled, `fault_n` stays low with no further edges, whether or not the overcurrent persists; only a disable or a supply loss releases it.
- R7: If the overcurrent flag clears during regulation, the channel returns to conduction on the next clock and the grace count restarts from zero at the next overcurrent.
- R8: Disabling a channel that is conducting normally selects the slow ramped shutdown (`pull_slow`=1).
- R9: Disabling a channel that is regulating or latched selects the fast pulldown (`pull_fast`=1), which is held while the channel stays off.
- R10: One clock after a channel is disabled or the supply drops, `out_clamp` is high; it is low whenever the channel is powered. Overcurrent flags on a disabled channel have no effect.
- R11: Asynchronous reset puts every channel off with `pull_slow`=1, `out_clamp`=1, `fault_n`=1 and `drive_on`=`drive_reg`=`pull_fast`=0.
- R12: For each channel exactly one of `drive_on`, `drive_reg`, `pull_fast`, `pull_slow` is high at all times.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sup_ok | input | 1 | Input supply above undervoltage threshold (shared) |
| ch_en | input | NCH | Per-channel enable, active high |
| oc_flag | input | NCH | Per-channel overcurrent detect, active high |
| drive_on | output | NCH | Gate ramped up / normal conduction |
| drive_reg | output | NCH | Gate in current-regulation mode |
| pull_fast | output | NCH | Fast gate pulldown (latched or fast shutdown) |
| pull_slow | output | NCH | Slow ramped gate shutdown |
| out_clamp | output | NCH | Active output pulldown while disabled |
| fault_n | output | NCH | Fault report, active low |

## Verification
A wrong channel state shows up as a mode output one clock after the input change that should have caused it. Examples are a regulation mode that never entered, or a shutdown of the wrong speed. A blanking or grace count that is off by one moves the falling edge of `fault_n` or the rise of `pull_fast` by a whole clock. The bench therefore samples on the exact cycles on both sides of each expiry. A latch that releases too early, or a timer that is not cleared, becomes visible only later: as a second fault edge while the channel is still enabled, or as a latch that arrives early after a short overcurrent burst. The stimulus holds those conditions for long stretches so that these delayed failures have time to appear.

// File: rtl/ocp_latch_ctrl.sv
module ocp_latch_ctrl #(
  parameter int NCH         = 2,
  parameter int CLK_HZ      = 125_000_000,
  parameter int HOLD_MS     = 12,
  parameter int BLANK_TICKS = CLK_HZ / 1000 * HOLD_MS,
  parameter int GRACE_TICKS = CLK_HZ / 1000 * HOLD_MS
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sup_ok,
  input  logic [NCH-1:0] ch_en,
  input  logic [NCH-1:0] oc_flag,
  output logic [NCH-1:0] drive_on,
  output logic [NCH-1:0] drive_reg,
  output logic [NCH-1:0] pull_fast,
  output logic [NCH-1:0] pull_slow,
  output logic [NCH-1:0] out_clamp,
  output logic [NCH-1:0] fault_n
);

  localparam int BW = $clog2(BLANK_TICKS + 1);
  localparam int GW = $clog2(GRACE_TICKS + 1);
  localparam logic [BW-1:0] BLANK_END = BW'(BLANK_TICKS);
  localparam logic [GW-1:0] GRACE_END = GW'(GRACE_TICKS - 1);

  typedef enum logic [1:0] {S_OFF, S_ON, S_REG, S_LATCH} st_t;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    st_t           st;
    logic [BW-1:0] bcnt;
    logic [GW-1:0] gcnt;
    logic          fast_q;
    logic          act;
    logic          blanked;

    assign act     = ch_en[c] & sup_ok;
    assign blanked = (bcnt == BLANK_END);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st     <= S_OFF;
        fast_q <= 1'b0;
        gcnt   <= '0;
      end else if (!act) begin
        if (st != S_OFF) fast_q <= (st == S_REG) || (st == S_LATCH);
        st   <= S_OFF;
        gcnt <= '0;
      end else begin
        unique case (st)
          S_OFF: begin
            st   <= S_ON;
            gcnt <= '0;
          end
          S_ON: begin
            gcnt <= '0;
            if (oc_flag[c]) st <= S_REG;
          end
          S_REG: begin
            if (!oc_flag[c]) begin
              st   <= S_ON;
              gcnt <= '0;
            end else if (gcnt == GRACE_END) begin
              st <= S_LATCH;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
          default: st <= S_LATCH;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   bcnt <= '0;
      else if (!act || st == S_OFF) bcnt <= '0;
      else if (!blanked)            bcnt <= bcnt + 1'b1;
    end

    assign drive_on[c]  = (st == S_ON);
    assign drive_reg[c] = (st == S_REG);
    assign pull_fast[c] = (st == S_LATCH) || (st == S_OFF && fast_q);
    assign pull_slow[c] = (st == S_OFF) && !fast_q;
    assign out_clamp[c] = (st == S_OFF);
    assign fault_n[c]   = !((st == S_LATCH) && blanked);
  end

endmodule

// File: rtl/ocp_latch_ctrl_chk.sv
module ocp_latch_ctrl_chk #(
  parameter int NCH = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sup_ok,
  input logic [NCH-1:0] ch_en,
  input logic [NCH-1:0] oc_flag,
  input logic [NCH-1:0] drive_on,
  input logic [NCH-1:0] drive_reg,
  input logic [NCH-1:0] pull_fast,
  input logic [NCH-1:0] pull_slow,
  input logic [NCH-1:0] out_clamp,
  input logic [NCH-1:0] fault_n
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r12_one_mode: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({drive_on[c], drive_reg[c], pull_fast[c], pull_slow[c]}) == 1);

    a_r2_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[c] || !sup_ok) |=> (!drive_on[c] && !drive_reg[c]));

    a_r10_clamp_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en[c] || !sup_ok) |=> out_clamp[c]);

    a_r6_fault_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!fault_n[c] && ch_en[c] && sup_ok) |=> !fault_n[c]);

    a_r5_fault_on_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fault_n[c]) |-> (pull_fast[c] && !out_clamp[c]));

    a_r4_reg_needs_oc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_reg[c]) |-> $past(oc_flag[c]));

    a_r9_fast_from_reg: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_reg[c] && (!ch_en[c] || !sup_ok)) |=> pull_fast[c]);

    a_r8_slow_from_on: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_on[c] && (!ch_en[c] || !sup_ok)) |=> pull_slow[c]);
  end

endmodule

bind ocp_latch_ctrl ocp_latch_ctrl_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ch_en(ch_en), .oc_flag(oc_flag),
  .drive_on(drive_on), .drive_reg(drive_reg), .pull_fast(pull_fast),
  .pull_slow(pull_slow), .out_clamp(out_clamp), .fault_n(fault_n)
);

// File: tb/ocp_latch_ctrl_tb.sv
module ocp_latch_ctrl_tb;

  localparam int BL = 20;
  localparam int GR = 8;
  localparam int NV = 25;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sup_ok = 1'b0;
  logic [1:0] ch_en = 2'b00;
  logic [1:0] oc_flag = 2'b00;
  logic [1:0] drive_on, drive_reg, pull_fast, pull_slow, out_clamp, fault_n;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ocp_latch_ctrl #(.NCH(2), .BLANK_TICKS(BL), .GRACE_TICKS(GR)) u_dut (
    .clk(clk), .rst_n(rst_n), .sup_ok(sup_ok), .ch_en(ch_en), .oc_flag(oc_flag),
    .drive_on(drive_on), .drive_reg(drive_reg), .pull_fast(pull_fast),
    .pull_slow(pull_slow), .out_clamp(out_clamp), .fault_n(fault_n)
  );

  // {en, oc, sup, cycles, on, reg, fast, slow, clamp, fault_n}; 2-bit fields are {ch1, ch0}
  localparam logic [24:0] VEC [NV] = '{
    {2'b11, 2'b00, 1'b1, 8'd1,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b01, 1'b1, 8'd1,  2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b01, 1'b1, 8'd7,  2'b10, 2'b01, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b01, 1'b1, 8'd1,  2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b01, 1'b1, 8'd10, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b01, 1'b1, 8'd1,  2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10},
    {2'b11, 2'b01, 1'b1, 8'd30, 2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10},
    {2'b11, 2'b00, 1'b1, 8'd5,  2'b10, 2'b00, 2'b01, 2'b00, 2'b00, 2'b10},
    {2'b10, 2'b00, 1'b1, 8'd1,  2'b10, 2'b00, 2'b01, 2'b00, 2'b01, 2'b11},
    {2'b10, 2'b01, 1'b1, 8'd4,  2'b10, 2'b00, 2'b01, 2'b00, 2'b01, 2'b11},
    {2'b11, 2'b00, 1'b1, 8'd1,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b01, 2'b00, 1'b1, 8'd1,  2'b01, 2'b00, 2'b00, 2'b10, 2'b10, 2'b11},
    {2'b11, 2'b00, 1'b1, 8'd1,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd5,  2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b00, 1'b1, 8'd1,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd7,  2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd1,  2'b01, 2'b10, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd1,  2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd4,  2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b10, 1'b1, 8'd1,  2'b01, 2'b00, 2'b10, 2'b00, 2'b00, 2'b01},
    {2'b11, 2'b11, 1'b1, 8'd1,  2'b00, 2'b01, 2'b10, 2'b00, 2'b00, 2'b01},
    {2'b10, 2'b11, 1'b1, 8'd1,  2'b00, 2'b00, 2'b11, 2'b00, 2'b01, 2'b01},
    {2'b11, 2'b00, 1'b0, 8'd1,  2'b00, 2'b00, 2'b11, 2'b00, 2'b11, 2'b11},
    {2'b11, 2'b00, 1'b1, 8'd1,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11},
    {2'b11, 2'b00, 1'b1, 8'd3,  2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11}
  };

  function automatic string tag_of(int i);
    case (i)
      0, 23:                 return "R2";
      1, 13:                 return "R4";
      2, 5, 17, 19:          return "R5";
      3, 4, 10, 18:          return "R3";
      6, 7:                  return "R6";
      8, 21:                 return "R9";
      9, 22:                 return "R10";
      11:                    return "R8";
      12, 20:                return "R1";
      14, 15, 16:            return "R7";
      default:               return "R12";
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [1:0] act, logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic chk_all(string tag, logic [11:0] e);
    chk(tag, "drive_on",  drive_on,  e[11:10]);
    chk(tag, "drive_reg", drive_reg, e[9:8]);
    chk(tag, "pull_fast", pull_fast, e[7:6]);
    chk(tag, "pull_slow", pull_slow, e[5:4]);
    chk(tag, "out_clamp", out_clamp, e[3:2]);
    chk(tag, "fault_n",   fault_n,   e[1:0]);
    for (int c = 0; c < 2; c++) begin
      checks++;
      if ($countones({drive_on[c], drive_reg[c], pull_fast[c], pull_slow[c]}) != 1) begin
        fails++;
        $display("FAIL R12 mode not one-hot ch%0d actual=%b expected=one-hot", c,
                 {drive_on[c], drive_reg[c], pull_fast[c], pull_slow[c]});
      end
    end
  endtask

  task automatic finish_up();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(8 * 100_000);
    fails++;
    $display("FAIL R11 watchdog actual=hang expected=done");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11 reset state
    chk_all("R11", {2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11});
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      ch_en   = VEC[i][24:23];
      oc_flag = VEC[i][22:21];
      sup_ok  = VEC[i][20];
      repeat (int'(VEC[i][19:12])) @(posedge clk);
      #1;
      chk_all(tag_of(i), VEC[i][11:0]);
    end

    // R2: enable held with supply low keeps both channels off
    @(negedge clk);
    sup_ok = 1'b0; ch_en = 2'b11; oc_flag = 2'b00;
    repeat (5) @(posedge clk);
    #1;
    chk("R2", "drive_on supply low", drive_on, 2'b00);
    chk("R10", "out_clamp supply low", out_clamp, 2'b11);
    @(negedge clk);
    sup_ok = 1'b1;
    @(posedge clk);
    #1;
    chk("R2", "drive_on supply restored", drive_on, 2'b11);

    // R11: asynchronous reset while conducting
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk_all("R11", {2'b00, 2'b00, 2'b00, 2'b11, 2'b11, 2'b11});
    @(negedge clk);
    rst_n = 1'b1;
    ch_en = 2'b00;
    repeat (2) @(posedge clk);
    finish_up();
  end

endmodule